// File: doc/BRIEF.md
# Serial Register Read Slave with Shared Lock Status Pin

This block is the slave side of a 32-clock serial read. A host raises the enable line. It then clocks in a one-bit command flag and a six-bit register address. After that it clocks out a 24-bit register word. All serial inputs are already synchronous to the block's system clock. The block finds the serial clock's rising edges with a one-flop edge detector and counts them within the frame.

Once the last address bit arrives, the block sends the address to an external register-file read port for one cycle, together with a read strobe. It then loads the returned word into an output shift register. The single output pin is shared between two uses:

- Outside the data phase it carries a lock status input.
- During the data phase it carries the serial data.

The lock value is frozen on the pin from the moment the frame opens until the first data bit appears. This keeps the pin from toggling while the host sends its command.

Top module: `pll_serial_rd_slave`

## Requirements
- R1: During and straight after reset, `sdo` equals `lock_in` and `rf_re` is 0.
- R2: Only rising `sclk` edges seen while `sen` is high are counted. The first counted edge samples `sdi`, and the value 1 marks a read. With a 0 there, `rf_re` never pulses in that frame and `sdo` never carries data.
- R3: Counted edges 2 to 7 shift `sdi` into the address, most significant bit first. In the cycle after edge 7 of a read, `rf_re` is 1 for exactly one cycle and `rf_addr` holds the six-bit address.
- R4: After counted edge k (8 ≤ k ≤ 31) of a read, `sdo` shows bit 31−k of the returned word, so bit 23 comes first and bit 0 comes last.
- R5: From counted edge 32 until `sen` falls, `sdo` follows `lock_in` live.
- R6: While `sen` is high and fewer than 8 edges have been counted, `sdo` holds the `lock_in` value that was sampled in the last cycle before `sen` rose. This applies to read and non-read frames alike.
- R7: Dropping `sen` at any point ends the frame. `sdo` follows `lock_in` at once, and the next frame starts counting from edge 1.
- R8: Edges after the 32nd within one frame are ignored, and `sdo` stays on live `lock_in`.
- R9: Rising `sclk` edges while `sen` is low change no state: `sdo` follows `lock_in`, and a following frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| sen | input | 1 | Frame enable, high during a transaction |
| sdi | input | 1 | Serial command and address input |
| lock_in | input | 1 | Lock status shown on the shared pin |
| rf_addr | output | 6 | Register-file read address |
| rf_re | output | 1 | One-cycle register-file read strobe |
| rf_rdata | input | 24 | Register-file read data, valid in the strobe cycle |
| sdo | output | 1 | Shared pin: serial data or lock status |

## Verification
The assertions rely on a few properties of the inputs:

- `sclk`, `sen` and `sdi` change only between system-clock edges.
- `sclk` is low when reset is released.
- Each `sclk` level lasts at least one system cycle, so the fetch after edge 7 completes before edge 8.
- `rf_rdata` is valid combinationally in the cycle `rf_re` is high.

The bench keeps within these limits. It drives every input on the falling clock edge and holds each `sclk` level for three cycles. It serves reads from a combinational function of `rf_addr`. It also toggles `lock_in` on its own schedule, which puts the freeze window and the live windows under test.

// File: rtl/pllrd_pkg.sv
package pllrd_pkg;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 24;
    localparam int CMD_W      = 1;
    localparam int FIRST_DATA = CMD_W + ADDR_W + 1;   // edge that shows the first data bit
    localparam int LAST_EDGE  = FIRST_DATA + DATA_W;  // edge that restores lock status
    localparam int CNT_W      = $clog2(LAST_EDGE + 1);

    typedef logic [CNT_W-1:0]  edge_cnt_t;
    typedef logic [ADDR_W-1:0] reg_addr_t;
    typedef logic [DATA_W-1:0] reg_word_t;

    typedef struct packed {
        edge_cnt_t cnt;
        logic      is_read;
        reg_addr_t addr;
    } frame_t;

    function automatic logic in_data_phase(input edge_cnt_t c);
        return (c >= edge_cnt_t'(FIRST_DATA)) && (c <= edge_cnt_t'(LAST_EDGE - 1));
    endfunction

    function automatic logic shifts_on_edge(input edge_cnt_t c);
        return (c >= edge_cnt_t'(FIRST_DATA)) && (c <= edge_cnt_t'(LAST_EDGE - 2));
    endfunction
endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic rise
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
endmodule

// File: rtl/rd_frame_seq.sv
module rd_frame_seq
    import pllrd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sen,
    input  logic   sdi,
    input  logic   rise,
    output frame_t frame,
    output logic   fetch
);
    frame_t st;
    logic   fetch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            fetch_q <= 1'b0;
        end else begin
            fetch_q <= 1'b0;
            if (!sen) begin
                st.cnt     <= '0;
                st.is_read <= 1'b0;
            end else if (rise && st.cnt != edge_cnt_t'(LAST_EDGE)) begin
                st.cnt <= st.cnt + 1'b1;
                if (st.cnt == '0)
                    st.is_read <= sdi;
                else if (st.cnt <= edge_cnt_t'(CMD_W + ADDR_W - 1))
                    st.addr <= {st.addr[ADDR_W-2:0], sdi};
                if (st.cnt == edge_cnt_t'(CMD_W + ADDR_W - 1) && st.is_read)
                    fetch_q <= 1'b1;
            end
        end
    end

    assign frame = st;
    assign fetch = fetch_q;

    assert_fetch_point_R3: assert property (@(posedge clk) disable iff (rst)
        fetch |-> (st.cnt == edge_cnt_t'(CMD_W + ADDR_W) && st.is_read));
    assert_fetch_single_R3: assert property (@(posedge clk) disable iff (rst)
        fetch |=> !fetch);
    assert_nonread_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !st.is_read |-> !fetch);
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        st.cnt <= edge_cnt_t'(LAST_EDGE));
    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !sen |=> (st.cnt == '0 && !st.is_read));
endmodule

// File: rtl/rd_out_path.sv
module rd_out_path
    import pllrd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sen,
    input  logic      lock_in,
    input  logic      rise,
    input  logic      fetch,
    input  frame_t    frame,
    input  reg_word_t rf_rdata,
    output logic      sdo
);
    reg_word_t shreg;
    logic      lock_frz;
    logic      show_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            lock_frz <= 1'b0;
        end else begin
            if (!sen)
                lock_frz <= lock_in;
            if (fetch)
                shreg <= rf_rdata;
            else if (sen && rise && frame.is_read && shifts_on_edge(frame.cnt))
                shreg <= {shreg[DATA_W-2:0], 1'b0};
        end
    end

    assign show_data = sen && frame.is_read && in_data_phase(frame.cnt);

    always_comb begin
        if (show_data)
            sdo = shreg[DATA_W-1];
        else if (sen && frame.cnt < edge_cnt_t'(FIRST_DATA))
            sdo = lock_frz;
        else
            sdo = lock_in;
    end

    assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (sen && $past(sen) && frame.cnt < edge_cnt_t'(FIRST_DATA)) |-> $stable(sdo));
    assert_idle_live_R7: assert property (@(posedge clk) disable iff (rst)
        !sen |-> (sdo == lock_in));
    assert_restore_live_R5: assert property (@(posedge clk) disable iff (rst)
        (sen && frame.cnt == edge_cnt_t'(LAST_EDGE)) |-> (sdo == lock_in));
    assert_nonread_pin_R2: assert property (@(posedge clk) disable iff (rst)
        (sen && !frame.is_read && frame.cnt >= edge_cnt_t'(FIRST_DATA)) |-> (sdo == lock_in));
endmodule

// File: rtl/pll_serial_rd_slave.sv
module pll_serial_rd_slave
    import pllrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sen,
    input  logic              sdi,
    input  logic              lock_in,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_re,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              sdo
);
    logic   rise;
    logic   fetch;
    frame_t frame;

    sclk_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .rise (rise)
    );

    rd_frame_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .sen   (sen),
        .sdi   (sdi),
        .rise  (rise),
        .frame (frame),
        .fetch (fetch)
    );

    rd_out_path u_out (
        .clk      (clk),
        .rst      (rst),
        .sen      (sen),
        .lock_in  (lock_in),
        .rise     (rise),
        .fetch    (fetch),
        .frame    (frame),
        .rf_rdata (rf_rdata),
        .sdo      (sdo)
    );

    assign rf_addr = frame.addr;
    assign rf_re   = fetch;

    assert_reset_pin_R1: assert property (@(posedge clk)
        rst |=> (!rf_re && sdo == lock_in));
endmodule

// File: tb/pll_serial_rd_slave_bench.sv
module pll_serial_rd_slave_bench;
    localparam int HP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, sen = 1'b0, sdi = 1'b0, lock_in = 1'b0;
    logic [5:0]  rf_addr;
    logic        rf_re;
    logic [23:0] rf_rdata;
    logic        sdo;

    int n_checks = 0, n_fail = 0, cycles = 0, re_pulses = 0;
    bit running = 1'b1;

    // behavioural reference state
    int  m_cnt = 0, m_addr = 0;
    bit  m_read = 0, m_re = 0, m_frz = 0, m_prev = 0;

    always #4 clk = ~clk;

    function automatic logic [23:0] rfval(input logic [5:0] a);
        return {a, ~a, a ^ 6'h2A, a + 6'd17};
    endfunction

    assign rf_rdata = rfval(rf_addr);

    pll_serial_rd_slave u_pll_serial_rd_slave (
        .clk(clk), .rst(rst), .sclk(sclk), .sen(sen), .sdi(sdi),
        .lock_in(lock_in), .rf_addr(rf_addr), .rf_re(rf_re),
        .rf_rdata(rf_rdata), .sdo(sdo)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit rise;
        logic [23:0] w;
        int exp_sdo;
        string req;
        rise = sclk && !m_prev;
        if (rst) begin
            m_cnt = 0; m_read = 0; m_addr = 0; m_re = 0; m_frz = 0; m_prev = 0;
        end else begin
            m_re = 0;
            if (!sen) begin
                m_cnt = 0; m_read = 0; m_frz = lock_in;
            end else if (rise && m_cnt < 32) begin
                m_cnt++;
                if (m_cnt == 1) m_read = sdi;
                else if (m_cnt <= 7) m_addr = ((m_addr << 1) | int'(sdi)) & 63;
                if (m_cnt == 7 && m_read) m_re = 1;
            end
            m_prev = sclk;
        end
        #2;
        if (running && !rst) begin
            w = rfval(6'(m_addr));
            if (!sen) begin exp_sdo = lock_in; req = "R7"; end
            else if (m_read && m_cnt >= 8 && m_cnt <= 31) begin exp_sdo = w[31 - m_cnt]; req = "R4"; end
            else if (m_cnt < 8) begin exp_sdo = m_frz; req = "R6"; end
            else begin exp_sdo = lock_in; req = (m_cnt == 32) ? "R5" : "R2"; end
            check(req, sdo, exp_sdo);
            check("R3 strobe", rf_re, m_re);
            if (m_re) check("R3 addr", rf_addr, m_addr);
            if (rf_re) re_pulses++;
        end
    end

    // lock status toggles on its own schedule
    initial begin
        forever begin
            repeat (7) @(negedge clk);
            lock_in = ~lock_in;
        end
    end

    task automatic run_frame(input bit rd, input logic [5:0] a, input int edges, input int abort_at);
        @(negedge clk);
        sen = 1'b1; sdi = rd;
        repeat (HP) @(negedge clk);
        for (int k = 1; k <= edges; k++) begin
            if (k == abort_at) sen = 1'b0;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
            sdi = (k + 1 >= 2 && k + 1 <= 7) ? a[7 - (k + 1)] : 1'b0;
            repeat (HP) @(negedge clk);
        end
        sen = 1'b0; sdi = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2 check("R1 sdo", sdo, lock_in);
        check("R1 rf_re", rf_re, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #3 check("R1 after", sdo, lock_in);
        repeat (3) @(negedge clk);

        re_pulses = 0; run_frame(1'b1, 6'h2D, 32, 0);
        check("R3 one pulse", re_pulses, 1);
        run_frame(1'b1, 6'h00, 32, 0);
        run_frame(1'b1, 6'h3F, 32, 0);
        re_pulses = 0; run_frame(1'b0, 6'h15, 32, 0);
        check("R2 no pulse", re_pulses, 0);
        run_frame(1'b1, 6'h2A, 35, 0);          // R8 extra edges
        re_pulses = 0; run_frame(1'b1, 6'h11, 20, 15); // R7 abort mid-data
        check("R7 fetched once", re_pulses, 1);
        run_frame(1'b1, 6'h0C, 32, 0);          // R7 fresh frame after abort
        for (int k = 0; k < 6; k++) begin       // R9 clocks with enable low
            sclk = 1'b1; sdi = k[0]; repeat (HP) @(negedge clk);
            sclk = 1'b0; repeat (HP) @(negedge clk);
        end
        run_frame(1'b1, 6'h33, 32, 0);          // R9 normal decode afterwards
        run_frame(1'b1, 6'h01, 5, 4);           // R6/R7 abort during address
        repeat (10) @(negedge clk);
        running = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && running) begin
            running = 1'b0;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule